// File: doc/BRIEF.md
# Calibrated Real-Time Seconds Counter

This block is a real-time clock that keeps a 32-bit count of seconds. It is paced by an enable pulse from a slow oscillator of roughly 33.33 kHz. A tick divider counts those enables against a programmable calibration word. An integer part sets the base length of a second. A small fractional accumulator stretches some seconds by one extra enable, so the long-term rate can be trimmed finer than one enable per second.

Software reaches the block through a word-addressed register bus with separate read and write strobes. Read data is registered and appears on the clock after the read strobe.

Setting the time is deferred. A value written to the set-time register can be read back at once. It only replaces the running count at the next second boundary. A sticky seconds flag tells software whether a boundary has passed since it last cleared the flag. Rewriting the calibration word restarts the divider, so the next second is a full period long. A control register holds one read/write bit that enables switching to a backup battery.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, the current time, the set-time readback, the seconds flag and the control bit read 0. The calibration word resets to 0x198233, so the first second lasts 33332 oscillator enables.
- R2: Register byte offsets are: set-time write 0x00, set-time readback 0x04, calibration 0x08, current time 0x10, status 0x20, control 0x40. Read data appears one clock after the read strobe. Offsets 0x00 and 0x08 are write-only and read 0, and any unmapped offset reads 0.
- R3: Calibration bits 15:0 hold an integer N. A second boundary occurs on the edge that counts the (N+1)-th oscillator enable of a second, and the current time changes on the following clock. Clocks without an enable do not advance the divider.
- R4: Calibration bits 19:16 are added into a 4-bit accumulator at each boundary. A carry out makes the next second one enable longer. Bit 20 is stored but does not affect timing.
- R5: A calibration write clears the divider count and the accumulator, so the next boundary comes a full calibrated period after the write.
- R6: Reading the set-time readback register returns the last value written to offset 0x00, from the next read on.
- R7: A value written to offset 0x00 leaves the current time unchanged until the next boundary. At that boundary it is loaded, and the count then increments from it.
- R8: Status bit 0 sets on every second boundary, whether the time incremented or loaded. Writing 1 to it clears it. Writing 0 has no effect. A boundary in the same cycle as a clear wins.
- R9: Control bit 31 is read/write, and all other control bits read 0.
- R10: Writes to the current-time and readback offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The divider is run with its reset calibration, with a short integer period and no fraction, and with a short period plus a fraction that lengthens every second boundary's follower. The reset run and the short run together show that the integer field sets the period. The fractional run shows that the accumulator adds one extra enable on carry and that bit 20 is inert. A second calibration write issued mid-second tells a restarting divider apart from one that keeps counting. A set-time write made while the oscillator is held off shows that the new time waits for the boundary, and that incrementing then resumes from the loaded value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CAL_W     = 21;
  localparam int INT_W     = 16;
  localparam int FRAC_LSB  = 16;
  localparam int FRAC_W    = 4;
  localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;

  localparam logic [7:0] OFF_SET_WR = 8'h00;
  localparam logic [7:0] OFF_SET_RB = 8'h04;
  localparam logic [7:0] OFF_CAL    = 8'h08;
  localparam logic [7:0] OFF_NOW    = 8'h10;
  localparam logic [7:0] OFF_STAT   = 8'h20;
  localparam logic [7:0] OFF_CTRL   = 8'h40;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic              restart,
  input  logic [INT_W-1:0]  int_cnt,
  input  logic [FRAC_W-1:0] frac_step,
  output logic              sec_tick
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  target;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic [FRAC_W:0]   acc_sum;

  always_comb begin
    target  = {1'b0, int_cnt} + {{INT_W{1'b0}}, ext_q};
    acc_sum = {1'b0, acc_q} + {1'b0, frac_step};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      ext_q    <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
        acc_q <= '0;
        ext_q <= 1'b0;
      end else if (osc_en) begin
        if (cnt_q == target) begin
          cnt_q    <= '0;
          sec_tick <= 1'b1;
          acc_q    <= acc_sum[FRAC_W-1:0];
          ext_q    <= acc_sum[FRAC_W];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: a restart never leaves a boundary pulse behind it
  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !sec_tick);
  // R3: a boundary only follows a counted oscillator enable
  a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !sec_tick);
endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              set_wr,
  input  logic [TIME_W-1:0] set_val,
  input  logic              flag_clr,
  output logic [TIME_W-1:0] now_time,
  output logic [TIME_W-1:0] set_shadow,
  output logic              sec_flag
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_time   <= '0;
      set_shadow <= '0;
      pend_q     <= 1'b0;
      sec_flag   <= 1'b0;
    end else begin
      if (sec_tick) begin
        if (pend_q) begin
          now_time <= set_shadow;
          pend_q   <= 1'b0;
        end else begin
          now_time <= now_time + 1'b1;
        end
      end
      if (set_wr) begin
        set_shadow <= set_val;
        pend_q     <= 1'b1;
      end
      if (sec_tick)
        sec_flag <= 1'b1;
      else if (flag_clr)
        sec_flag <= 1'b0;
    end
  end

  // R3 / R7: time moves only on a boundary
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(now_time));
  // R3: free-running boundary adds exactly one
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !pend_q) |=> (now_time == $past(now_time) + 1'b1));
  // R8: every boundary raises the flag
  a_r8_flag_on_tick: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> sec_flag);
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  import rtc_pkg::*;

  localparam logic [ADDR_W-1:0] A_SET_WR = ADDR_W'(OFF_SET_WR);
  localparam logic [ADDR_W-1:0] A_SET_RB = ADDR_W'(OFF_SET_RB);
  localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(OFF_CAL);
  localparam logic [ADDR_W-1:0] A_NOW    = ADDR_W'(OFF_NOW);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

  logic [CAL_W-1:0]  cal_q;
  logic              bat_q;
  logic              wr_cal, wr_set, wr_stat, wr_ctrl;
  logic              sec_tick, sec_flag;
  logic [DATA_W-1:0] now_time, set_shadow, rd_val;
  logic              rd_mapped;

  always_comb begin
    wr_cal  = bus_wr && (bus_addr == A_CAL);
    wr_set  = bus_wr && (bus_addr == A_SET_WR);
    wr_stat = bus_wr && (bus_addr == A_STAT);
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= CAL_RESET;
      bat_q <= 1'b0;
    end else begin
      if (wr_cal)  cal_q <= bus_wdata[CAL_W-1:0];
      if (wr_ctrl) bat_q <= bus_wdata[DATA_W-1];
    end
  end

  rtc_tick_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .osc_en    (osc_en),
    .restart   (wr_cal),
    .int_cnt   (cal_q[INT_W-1:0]),
    .frac_step (cal_q[FRAC_LSB +: FRAC_W]),
    .sec_tick  (sec_tick)
  );

  rtc_time_keeper #(.TIME_W(DATA_W)) u_keep (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .set_wr     (wr_set),
    .set_val    (bus_wdata),
    .flag_clr   (wr_stat && bus_wdata[0]),
    .now_time   (now_time),
    .set_shadow (set_shadow),
    .sec_flag   (sec_flag)
  );

  always_comb begin
    rd_val    = '0;
    rd_mapped = 1'b1;
    case (bus_addr)
      A_SET_RB: rd_val = set_shadow;
      A_NOW:    rd_val = now_time;
      A_STAT:   rd_val = {{(DATA_W-1){1'b0}}, sec_flag};
      A_CTRL:   rd_val = {bat_q, {(DATA_W-1){1'b0}}};
      default:  rd_mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_val;
  end

  // R2: write-only and unmapped offsets read as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rd_mapped) |=> (bus_rdata == '0));
  // R9: control readback carries only the top bit
  a_r9_ctrl_shape: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL) |=> (bus_rdata[DATA_W-2:0] == '0));
endmodule

// File: tb/test_rtc_seconds_core.sv
module test_rtc_seconds_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rtc_seconds_core i_rtc_seconds_core (
    .clk(clk), .rst(rst), .osc_en(osc_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata)
  );

  // monitor: pops one expectation per completed read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // boundaries whose time update lands on or before cycle k after a restart
  function automatic int sec_updates(int k, int iv, int fr);
    int t = 0, acc = 0, ext = 0, n = 0, b;
    for (int s = 0; s < 100000; s++) begin
      b = t + iv + 1 + ext;
      if (b + 1 > k) break;
      n++;
      acc = acc + fr;
      ext = (acc >= 16) ? 1 : 0;
      acc = acc % 16;
      t = b;
    end
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1, R2, R9: reset state and zero reads
    rd(8'h10, 32'd0, "R1 time at reset");
    rd(8'h04, 32'd0, "R1 readback at reset");
    rd(8'h20, 32'd0, "R1 flag at reset");
    rd(8'h40, 32'd0, "R1 R9 control at reset");
    rd(8'h08, 32'd0, "R2 calibration write-only");
    rd(8'h00, 32'd0, "R2 set-time write-only");
    rd(8'h0C, 32'd0, "R2 unmapped offset");

    // R1: default calibration gives a 33332-enable second
    osc_en = 1'b1;
    for (int k = 0; k < 33335; k++) begin
      if (k == 33332)      rd(8'h20, 32'd0, "R1 default period not yet");
      else if (k == 33333) rd(8'h20, 32'd1, "R1 default period reached");
      else idle(1);
    end
    osc_en = 1'b0;
    base = sec_updates(33336, 33331, 9);
    rd(8'h10, base, "R1 time after default second");
    wr(8'h20, 32'd1);
    rd(8'h20, 32'd0, "R8 flag cleared");

    // R3: integer period 4 enables, flag set on first boundary
    osc_en = 1'b1;
    wr(8'h08, 32'd3);
    for (int k = 0; k < 12; k++) begin
      n = sec_updates(k, 3, 0);
      if (k == 2 || k == 7) rd(8'h20, (n > 0) ? 32'd1 : 32'd0, "R8 flag vs boundary");
      else rd(8'h10, base + n, "R3 integer period");
    end
    osc_en = 1'b0;
    base = base + sec_updates(13, 3, 0);
    idle(10);
    rd(8'h10, base, "R3 frozen without enables");

    // R8, R10, R9, R6, R7 with the oscillator held off
    wr(8'h20, 32'd0);
    rd(8'h20, 32'd1, "R8 write 0 keeps flag");
    wr(8'h20, 32'd1);
    rd(8'h20, 32'd0, "R8 write 1 clears flag");
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, base, "R10 time write ignored");
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, 32'd0, "R10 readback write ignored");
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h8000_0000, "R9 control set");
    wr(8'h40, 32'h7FFF_FFFF);
    rd(8'h40, 32'd0, "R9 control cleared");
    wr(8'h00, 32'd1000);
    rd(8'h04, 32'd1000, "R6 readback");
    rd(8'h10, base, "R7 load deferred");
    idle(5);
    rd(8'h10, base, "R7 still deferred");

    // R4, R7: fraction 8 with bit 20 set; first boundary loads 1000
    osc_en = 1'b1;
    wr(8'h08, 32'h0018_0003);
    for (int k = 0; k < 30; k++) begin
      n = sec_updates(k, 3, 8);
      if (k == 12) rd(8'h20, (n > 0) ? 32'd1 : 32'd0, "R8 flag on load boundary");
      else rd(8'h10, (n == 0) ? base : 32'd1000 + n - 1, "R4 R7 fractional seconds");
    end
    osc_en = 1'b0;
    n = sec_updates(31, 3, 8);
    base = 1000 + n - 1;
    idle(3);
    rd(8'h10, base, "R4 count after fractional run");

    // R5: calibration rewrite mid-second restarts the divider
    osc_en = 1'b1;
    wr(8'h08, 32'd7);
    for (int k = 0; k < 5; k++) rd(8'h10, base, "R5 before rewrite");
    wr(8'h08, 32'd7);
    for (int k = 0; k < 12; k++)
      rd(8'h10, base + sec_updates(k, 7, 0), "R5 full period after rewrite");
    osc_en = 1'b0;
    idle(3);

    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R2 read count: got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule